// File: doc/BRIEF.md
# Key-Protected Second Alarm and Power-Off Controller

This block sits beside a calendar clock core. It guards a small bank of control registers behind a two-word key sequence, holds a second full-date alarm, and uses that alarm to switch off an external power regulator. The clock core supplies the current time as six BCD bytes, together with a one-cycle strobe on each update. Software reaches the block through a simple word-wide register port with combinational read data.

Software opens the bank by writing the first key to the first kick register and then the second key to the second kick register. It then programs the alarm date, the interrupt enable, the wake enable and the power-off arm bit. Writing zero, or any other wrong word, to a kick register closes the bank again. When the alarm date equals the current time on an update strobe, the block sets a sticky status flag. If the arm bit is set at that moment, it also pulls `pmic_power_en` low. The pin stays low until reset.

Top module: `rtc_pwroff`

## Requirements
- R1: After reset the bank is locked, every register reads 0, `irq_alarm2` is 0, `alarm_wake_en` is 0 and `pmic_power_en` is 1.
- R2: While locked, writes to any address other than the two kick registers change nothing, and reads still return the current register values.
- R3: Writing 0x83E70B13 to the kick register at 0x6C and then 0x95A4F1E0 to the kick register at 0x70 unlocks the bank. Register writes take effect at the clock edge that samples them and are visible on the read port in the next cycle.
- R4: Any other word written to 0x6C or 0x70 locks the bank, zero included. The 0x70 key does not unlock the bank unless 0x6C last received its key.
- R5: Alarm field i sits at 0x80+4*i in bits 7:0 (i=0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year). Field i is matched against `time_now[8*i+7:8*i]`. A cycle in which `time_tick` is high and all six fields match sets the alarm flag, which reads as bit 7 at 0x44.
- R6: Writing 0x44 with bit 7 set clears the flag, but only while unlocked. If an alarm event falls in the same cycle as the clear, the flag stays set.
- R7: `irq_alarm2` is high exactly when the flag is set and bit 4 at 0x48 (alarm interrupt enable) is set.
- R8: Bit 16 at 0x98 arms power-off. An alarm event while armed drives `pmic_power_en` low from the next cycle until reset. An event while unarmed leaves it high. Clearing the arm bit does not raise the pin again.
- R9: Bit 1 at 0x7C is the alarm wake enable and drives `alarm_wake_en` directly.
- R10: A full match with `time_tick` low raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| time_tick | input | 1 | One-cycle strobe when the clock core presents a new time |
| time_now | input | 48 | Current time, six BCD bytes, seconds in the low byte |
| irq_alarm2 | output | 1 | Alarm interrupt request |
| alarm_wake_en | output | 1 | Alarm wake enable |
| pmic_power_en | output | 1 | Regulator enable, high means power on |

## Verification
An alarm event and a software write to the status or arm register can land on the same clock edge. The bench provokes this by asserting `time_tick` with a matching time in the very cycle that carries a flag-clear write. It expects the flag to survive, because the event wins. A second case writes the arm bit on the same cycle as an event; the bench expects the old arm value to decide the pin. A behavioural model in the bench is compared with every output and with the read port on every clock.

// File: rtl/rtc_pwroff.sv
module rtc_pwroff #(
  parameter int          ADDR_W = 8,
  parameter int          FIELDS = 6,
  parameter logic [31:0] KEY0   = 32'h83E70B13,
  parameter logic [31:0] KEY1   = 32'h95A4F1E0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                time_tick,
  input  logic [8*FIELDS-1:0] time_now,
  output logic                irq_alarm2,
  output logic                alarm_wake_en,
  output logic                pmic_power_en
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_KICK0 = ADDR_W'(8'h6C);
  localparam logic [ADDR_W-1:0] A_KICK1 = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] A_WAKE  = ADDR_W'(8'h7C);
  localparam logic [ADDR_W-1:0] A_ALM   = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] A_PMIC  = ADDR_W'(8'h98);

  logic              unlocked, key0_ok;
  logic              ie_a2, flag, wake, arm, pmic_q;
  logic [7:0]        alm [FIELDS];
  logic [FIELDS-1:0] fmatch;
  logic              event_a2, wr_ok;

  assign wr_ok    = bus_wr && unlocked;
  assign event_a2 = time_tick && (&fmatch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      key0_ok  <= 1'b0;
    end else if (bus_wr && bus_addr == A_KICK0) begin
      if (bus_wdata == KEY0) key0_ok <= 1'b1;
      else begin
        key0_ok  <= 1'b0;
        unlocked <= 1'b0;
      end
    end else if (bus_wr && bus_addr == A_KICK1) begin
      unlocked <= key0_ok && (bus_wdata == KEY1);
    end
  end

  for (genvar i = 0; i < FIELDS; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rst_n) alm[i] <= 8'h00;
      else if (wr_ok && bus_addr == A_ALM + ADDR_W'(4*i)) alm[i] <= bus_wdata[7:0];
    end
    assign fmatch[i] = (time_now[8*i +: 8] == alm[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_a2  <= 1'b0;
      wake   <= 1'b0;
      arm    <= 1'b0;
      flag   <= 1'b0;
      pmic_q <= 1'b1;
    end else begin
      if (wr_ok && bus_addr == A_IEN)  ie_a2 <= bus_wdata[4];
      if (wr_ok && bus_addr == A_WAKE) wake  <= bus_wdata[1];
      if (wr_ok && bus_addr == A_PMIC) arm   <= bus_wdata[16];
      if (event_a2) flag <= 1'b1;
      else if (wr_ok && bus_addr == A_STAT && bus_wdata[7]) flag <= 1'b0;
      if (event_a2 && arm) pmic_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    case (bus_addr)
      A_STAT:  bus_rdata[7]  = flag;
      A_IEN:   bus_rdata[4]  = ie_a2;
      A_WAKE:  bus_rdata[1]  = wake;
      A_PMIC:  bus_rdata[16] = arm;
      default: bus_rdata = 32'h0;
    endcase
    for (int i = 0; i < FIELDS; i++)
      if (bus_addr == A_ALM + ADDR_W'(4*i)) bus_rdata = {24'h0, alm[i]};
  end

  assign irq_alarm2    = flag && ie_a2;
  assign alarm_wake_en = wake;
  assign pmic_power_en = pmic_q;
endmodule

module rtc_pwroff_chk #(
  parameter int          ADDR_W = 8,
  parameter logic [31:0] KEY1   = 32'h95A4F1E0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              pmic_power_en,
  input logic              irq_alarm2,
  input logic              unlocked,
  input logic              ie_a2,
  input logic              arm
);
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_wr) |=> ($stable(arm) && $stable(ie_a2)));
  assert_unlock_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && bus_addr == ADDR_W'(8'h70) && bus_wdata == KEY1));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm2 |-> ie_a2);
  assert_pmic_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pmic_power_en |=> !pmic_power_en);
  assert_pmic_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pmic_power_en) |-> $past(arm));
endmodule

bind rtc_pwroff rtc_pwroff_chk #(.ADDR_W(ADDR_W), .KEY1(KEY1)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pmic_power_en(pmic_power_en), .irq_alarm2(irq_alarm2),
  .unlocked(unlocked), .ie_a2(ie_a2), .arm(arm)
);

// File: tb/rtc_pwroff_test.sv
module rtc_pwroff_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        time_tick = 1'b0;
  logic [47:0] time_now = 48'h0;
  logic        irq_alarm2, alarm_wake_en, pmic_power_en;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_pwroff uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_tick(time_tick),
    .time_now(time_now), .irq_alarm2(irq_alarm2), .alarm_wake_en(alarm_wake_en),
    .pmic_power_en(pmic_power_en)
  );

  // behavioural reference
  bit       m_unl, m_k0, m_ie, m_st, m_arm, m_wake, m_pmic;
  bit [7:0] m_al [6];

  always @(posedge clk) begin
    bit ev, ok, nunl, nk0, nst;
    if (!rst_n) begin
      m_unl = 0; m_k0 = 0; m_ie = 0; m_st = 0; m_arm = 0; m_wake = 0; m_pmic = 1;
      foreach (m_al[i]) m_al[i] = 8'h00;
    end else begin
      ev = time_tick;
      for (int i = 0; i < 6; i++) if (time_now[8*i +: 8] != m_al[i]) ev = 0;
      ok = bus_wr && m_unl;
      nunl = m_unl; nk0 = m_k0; nst = m_st;
      if (bus_wr && bus_addr == 8'h6C) begin
        if (bus_wdata == K0) nk0 = 1; else begin nk0 = 0; nunl = 0; end
      end
      if (bus_wr && bus_addr == 8'h70) nunl = m_k0 && bus_wdata == K1;
      if (ok && bus_addr == 8'h44 && bus_wdata[7]) nst = 0;
      if (ev) nst = 1;
      if (ev && m_arm) m_pmic = 0;
      if (ok) begin
        if (bus_addr == 8'h48) m_ie = bus_wdata[4];
        if (bus_addr == 8'h7C) m_wake = bus_wdata[1];
        if (bus_addr == 8'h98) m_arm = bus_wdata[16];
        for (int i = 0; i < 6; i++) if (bus_addr == 8'h80 + 8'(4*i)) m_al[i] = bus_wdata[7:0];
      end
      m_unl = nunl; m_k0 = nk0; m_st = nst;
    end
  end

  function automatic logic [31:0] mrd(input logic [7:0] a);
    logic [31:0] v = 32'h0;
    if (a == 8'h44) v[7] = m_st;
    if (a == 8'h48) v[4] = m_ie;
    if (a == 8'h7C) v[1] = m_wake;
    if (a == 8'h98) v[16] = m_arm;
    for (int i = 0; i < 6; i++) if (a == 8'h80 + 8'(4*i)) v = {24'h0, m_al[i]};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 read port", bus_rdata, mrd(bus_addr));
    chk("R7 irq_alarm2", 32'(irq_alarm2), 32'(m_st && m_ie));
    chk("R9 alarm_wake_en", 32'(alarm_wake_en), 32'(m_wake));
    chk("R8 pmic_power_en", 32'(pmic_power_en), 32'(m_pmic));
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic tk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; time_tick = tk;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; time_tick = 1'b0;
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1'b1, a, d, 1'b0); endtask
  task automatic rd(input logic [7:0] a); cyc(1'b0, a, 32'h0, 1'b0); endtask

  task automatic unlock(); wr(8'h6C, K0); wr(8'h70, K1); endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h98);
    // R1 reset state
    chk("R1 pmic high", 32'(pmic_power_en), 32'h1);
    chk("R1 arm zero", bus_rdata, 32'h0);
    rd(8'h44); chk("R1 status zero", bus_rdata, 32'h0);
    chk("R1 irq low", 32'(irq_alarm2), 32'h0);

    // R2 locked writes ignored
    wr(8'h98, 32'h0001_0000); rd(8'h98); chk("R2 arm locked", bus_rdata, 32'h0);
    wr(8'h80, 32'h55); rd(8'h80); chk("R2 alarm locked", bus_rdata, 32'h0);

    // R4 second key alone
    wr(8'h70, K1); wr(8'h7C, 32'h2); chk("R4 key1 alone keeps lock", 32'(alarm_wake_en), 32'h0);
    wr(8'h6C, K0); wr(8'h70, 32'h1234); wr(8'h7C, 32'h2);
    chk("R4 bad key1 keeps lock", 32'(alarm_wake_en), 32'h0);

    // R3 unlock
    unlock();
    wr(8'h7C, 32'h2); chk("R3 R9 wake set after unlock", 32'(alarm_wake_en), 32'h1);
    wr(8'h80, 32'h30); wr(8'h84, 32'h59); wr(8'h88, 32'h23);
    wr(8'h8C, 32'h31); wr(8'h90, 32'h12); wr(8'h94, 32'h99);
    rd(8'h94); chk("R3 R5 year field", bus_rdata, 32'h99);
    rd(8'h88); chk("R5 hour field", bus_rdata, 32'h23);

    // R10 match without tick
    time_now = 48'h99_12_31_23_59_30;
    cyc(1'b0, 8'h44, 32'h0, 1'b0); chk("R10 no event without tick", bus_rdata, 32'h0);
    // near miss with tick
    time_now = 48'h99_12_31_23_59_31;
    cyc(1'b0, 8'h44, 32'h0, 1'b1); chk("R5 mismatch no event", bus_rdata, 32'h0);

    // R5 R7 R8 unarmed event, interrupt disabled
    time_now = 48'h99_12_31_23_59_30;
    cyc(1'b0, 8'h44, 32'h0, 1'b1);
    chk("R5 flag set", bus_rdata, 32'h80);
    chk("R7 irq masked", 32'(irq_alarm2), 32'h0);
    chk("R8 unarmed keeps power", 32'(pmic_power_en), 32'h1);
    wr(8'h48, 32'h10); chk("R7 irq enabled", 32'(irq_alarm2), 32'h1);

    // R6 clear
    wr(8'h44, 32'h80); rd(8'h44); chk("R6 cleared", bus_rdata, 32'h0);
    chk("R7 irq drops", 32'(irq_alarm2), 32'h0);
    // R6 event and clear in same cycle
    cyc(1'b1, 8'h44, 32'h80, 1'b1); chk("R6 event wins over clear", bus_rdata, 32'h80);

    // R4 lock with zeros, R2 clear ignored
    wr(8'h6C, 32'h0); wr(8'h70, 32'h0);
    wr(8'h44, 32'h80); rd(8'h44); chk("R2 R4 clear ignored when locked", bus_rdata, 32'h80);

    // R8 arm written in same cycle as event: old arm decides
    unlock();
    cyc(1'b1, 8'h98, 32'h0001_0000, 1'b1);
    chk("R8 old arm value decides", 32'(pmic_power_en), 32'h1);
    cyc(1'b0, 8'h98, 32'h0, 1'b1);
    chk("R8 armed event powers off", 32'(pmic_power_en), 32'h0);
    wr(8'h98, 32'h0); rd(8'h98);
    chk("R8 disarm read", bus_rdata, 32'h0);
    chk("R8 pin stays low", 32'(pmic_power_en), 32'h0);
    repeat (3) rd(8'h44);

    // R1 reset restores power
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(8'h80); chk("R1 pmic back high", 32'(pmic_power_en), 32'h1);
    chk("R1 alarm field cleared", bus_rdata, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule